// File: doc/BRIEF.md
# Processor trace status encoder

This block turns retirement and bus events from a simple in-order processor into a real-time trace stream. Each clock it drives a 4-bit status nibble (`pst`) and a 4-bit data nibble (`ddata`). The status nibble carries one of three things: an instruction-completion code, a marker that announces data about to appear, or the code that is held during exception processing. The processor reports at most one event per cycle. An event has a class, and it may carry an operand value with its size or a change-of-flow target address.

Operands and targets chosen for display are stored as records in a small FIFO. When the status nibble is free, a serializer removes the oldest record. It drives the record's marker on `pst`, then shifts the payload out on `ddata` one nibble per clock, least significant nibble first. Display rules suppress some records: capture enables, jump addressing modes, the reset-exception vector fetches, and block moves that turn into line bursts.

Top module: `trace_status_enc`

## Requirements
- R1: During reset and on the first idle cycle after it, `pst`, `ddata` and `overflow` are all 0.
- R2: An event sampled at clock edge k shows on `pst` after edge k. Class 0 (plain) and class 3 (block move) give 0x1. A cycle with no completion code, no marker and `exc_active` low gives 0x0.
- R3: For classes 0 and 3, an operand (`opnd_valid`) is queued only when `capture_en` is 1. The size field gives both the marker and the nibble count: size 0 (byte) gives marker 0x8 and 2 nibbles, size 1 (word) gives 0x9 and 4 nibbles, sizes 2 and 3 (longword) give 0xB and 8 nibbles. A record queued at edge k can show its marker on `pst` at the earliest after edge k+1. Its nibbles then follow on `ddata` after the next edges, least significant first. `ddata` is 0 whenever no nibble is being shifted out.
- R4: Class 1 (write debug data) gives completion code 0x4. Its operand is queued with the size marker whatever the value of `capture_en`.
- R5: Class 2 (change of flow) gives 0x5. A target is queued only when `tgt_valid` and `tgt_en` are both 1 and `flow_mode` is 1 (register indirect), 2 (displacement), 3 (indexed), 4 (PC indexed) or 5 (exception handler). Modes 0, 6 and 7 show no target. The target's marker depends on how far `tgt_addr` is from `cur_pc`. If the upper 16 bits are equal, the marker is 0x9 with 4 nibbles. Otherwise, if the upper 8 bits are equal, it is 0xA with 6 nibbles. Otherwise it is 0xB with 8 nibbles.
- R6: While `exc_active` is 1, `pst` shows 0xC on every cycle except a cycle that carries a marker or a class-2 0x5. The 0x1 and 0x4 completion codes are masked during this time.
- R7: Class 4 (exception stack write) and class 5 (exception vector read) give no completion code. Their operands are queued under `capture_en`. Class 5 operands are never queued while `exc_is_reset` is 1.
- R8: A class-3 operand is never queued when `blk_addr_lo` is 0 and `blk_regs` is 4 or more, even when `capture_en` is 1.
- R9: A completion code takes the status nibble ahead of a waiting marker, and the marker waits until a later free cycle. No new record is removed from the FIFO until every nibble of the previous record has been driven.
- R10: The FIFO holds `FIFO_DEPTH` records (8 by default). A record that arrives while the FIFO is full is dropped, and `overflow` goes to 1 and stays at 1 until reset.
- R11: Classes 6 and 7, and any cycle with `ev_valid` low, give no completion code and queue no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is reported this cycle |
| ev_class | input | 3 | Event class (0..7, see requirements) |
| exc_active | input | 1 | Exception processing in progress |
| exc_is_reset | input | 1 | The current exception is the reset exception |
| capture_en | input | 1 | Operand display enable |
| tgt_en | input | 1 | Branch target display enable |
| opnd_valid | input | 1 | The event carries an operand |
| opnd_size | input | 2 | Operand size: 0 byte, 1 word, 2/3 longword |
| opnd_data | input | 32 | Operand value |
| tgt_valid | input | 1 | The event carries a target address |
| tgt_addr | input | 32 | Change-of-flow target address |
| cur_pc | input | 32 | Address of the instruction that changes flow |
| flow_mode | input | 3 | Addressing mode of the jump |
| blk_addr_lo | input | 4 | Low 4 bits of the block-move start address |
| blk_regs | input | 5 | Number of registers in the block move |
| pst | output | 4 | Processor status nibble |
| ddata | output | 4 | Debug data nibble |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
A completion code is due one edge after its event. A marker is due one edge after its record is queued, unless a completion code or an unfinished payload holds it back. The payload nibbles follow on the next consecutive edges. The bench drives inputs just after a falling edge and updates its own model at the rising edge. It compares all three outputs at the next falling edge, so each expected value is checked against the edge that produced it. A few directed checks also rebuild a whole payload from the nibbles, counted from the event cycle, and compare it with the value that was sent.

// File: rtl/tse_pkg.sv
package tse_pkg;
  localparam int TRC_DW = 32;
  localparam int NIB_W  = 4;

  localparam logic [3:0] PST_IDLE = 4'h0;
  localparam logic [3:0] PST_DONE = 4'h1;
  localparam logic [3:0] PST_WDBG = 4'h4;
  localparam logic [3:0] PST_FLOW = 4'h5;
  localparam logic [3:0] PST_EXC  = 4'hC;
  localparam logic [3:0] MRK_B    = 4'h8;
  localparam logic [3:0] MRK_W    = 4'h9;
  localparam logic [3:0] MRK_3B   = 4'hA;
  localparam logic [3:0] MRK_L    = 4'hB;

  typedef enum logic [2:0] {
    EV_PLAIN      = 3'd0,
    EV_WDDATA     = 3'd1,
    EV_FLOW       = 3'd2,
    EV_BLKMOVE    = 3'd3,
    EV_EXC_WRITE  = 3'd4,
    EV_EXC_VECTOR = 3'd5
  } ev_class_e;

  typedef struct packed {
    logic [3:0]        marker;
    logic [3:0]        nibbles;
    logic [TRC_DW-1:0] data;
  } trace_rec_t;

  function automatic logic [3:0] opnd_marker(input logic [1:0] sz);
    case (sz)
      2'd0:    return MRK_B;
      2'd1:    return MRK_W;
      default: return MRK_L;
    endcase
  endfunction

  function automatic logic [3:0] opnd_nibbles(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] tgt_marker(input logic [TRC_DW-1:0] tgt,
                                            input logic [TRC_DW-1:0] pc);
    if (tgt[TRC_DW-1:16] == pc[TRC_DW-1:16]) return MRK_W;
    if (tgt[TRC_DW-1:24] == pc[TRC_DW-1:24]) return MRK_3B;
    return MRK_L;
  endfunction

  function automatic logic [3:0] tgt_nibbles(input logic [3:0] mrk);
    case (mrk)
      MRK_W:   return 4'd4;
      MRK_3B:  return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic flow_shows(input logic [2:0] mode);
    return (mode >= 3'd1) && (mode <= 3'd5);
  endfunction

  function automatic logic blk_burst(input logic [3:0] lo, input logic [4:0] regs);
    return (lo == 4'd0) && (regs >= 5'd4);
  endfunction
endpackage

// File: rtl/tse_classify.sv
module tse_classify
  import tse_pkg::*;
(
  input  logic              ev_valid,
  input  logic [2:0]        ev_class,
  input  logic              exc_active,
  input  logic              exc_is_reset,
  input  logic              capture_en,
  input  logic              tgt_en,
  input  logic              opnd_valid,
  input  logic [1:0]        opnd_size,
  input  logic [TRC_DW-1:0] opnd_data,
  input  logic              tgt_valid,
  input  logic [TRC_DW-1:0] tgt_addr,
  input  logic [TRC_DW-1:0] cur_pc,
  input  logic [2:0]        flow_mode,
  input  logic [3:0]        blk_addr_lo,
  input  logic [4:0]        blk_regs,
  output logic [3:0]        comp_code,
  output logic              rec_valid,
  output trace_rec_t        rec
);
  logic [3:0] raw_code;
  trace_rec_t opnd_rec, tgt_rec;

  always_comb begin
    opnd_rec.marker  = opnd_marker(opnd_size);
    opnd_rec.nibbles = opnd_nibbles(opnd_size);
    opnd_rec.data    = opnd_data;
    tgt_rec.marker   = tgt_marker(tgt_addr, cur_pc);
    tgt_rec.nibbles  = tgt_nibbles(tgt_rec.marker);
    tgt_rec.data     = tgt_addr;
  end

  always_comb begin
    raw_code  = PST_IDLE;
    rec_valid = 1'b0;
    rec       = opnd_rec;
    if (ev_valid) begin
      case (ev_class_e'(ev_class))
        EV_PLAIN: begin
          raw_code  = PST_DONE;
          rec_valid = opnd_valid && capture_en;
        end
        EV_WDDATA: begin
          raw_code  = PST_WDBG;
          rec_valid = opnd_valid;
        end
        EV_FLOW: begin
          raw_code  = PST_FLOW;
          rec_valid = tgt_valid && tgt_en && flow_shows(flow_mode);
          rec       = tgt_rec;
        end
        EV_BLKMOVE: begin
          raw_code  = PST_DONE;
          rec_valid = opnd_valid && capture_en && !blk_burst(blk_addr_lo, blk_regs);
        end
        EV_EXC_WRITE: rec_valid = opnd_valid && capture_en;
        EV_EXC_VECTOR: rec_valid = opnd_valid && capture_en && !exc_is_reset;
        default: begin
          raw_code  = PST_IDLE;
          rec_valid = 1'b0;
        end
      endcase
    end
    comp_code = (exc_active && raw_code != PST_FLOW) ? PST_IDLE : raw_code;
  end
endmodule

// File: rtl/tse_fifo.sv
module tse_fifo
  import tse_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  trace_rec_t push_rec,
  input  logic       pop,
  output trace_rec_t head_rec,
  output logic       empty,
  output logic       full,
  output logic       overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  trace_rec_t        mem [DEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     count;
  logic              wr_fire, rd_fire;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign wr_fire  = push && !full;
  assign rd_fire  = pop && !empty;
  assign head_rec = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= push_rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= bump(wr_ptr);
      if (rd_fire) rd_ptr <= bump(rd_ptr);
      count    <= count + CW'(wr_fire) - CW'(rd_fire);
      overflow <= overflow || (push && full);
    end
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/tse_serializer.sv
module tse_serializer
  import tse_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] comp_code,
  input  logic [3:0] base_code,
  input  trace_rec_t head_rec,
  input  logic       fifo_empty,
  output logic       pop,
  output logic       busy,
  output logic [3:0] pst,
  output logic [3:0] ddata
);
  logic [TRC_DW-1:0] shift;
  logic [3:0]        left;

  assign pop = !busy && !fifo_empty && (comp_code == PST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst   <= PST_IDLE;
      ddata <= 4'h0;
      busy  <= 1'b0;
      shift <= '0;
      left  <= '0;
    end else begin
      if (comp_code != PST_IDLE) pst <= comp_code;
      else if (pop)              pst <= head_rec.marker;
      else                       pst <= base_code;
      ddata <= busy ? shift[NIB_W-1:0] : 4'h0;
      if (busy) begin
        shift <= shift >> NIB_W;
        left  <= left - 1'b1;
        if (left == 4'd1) busy <= 1'b0;
      end else if (pop) begin
        busy  <= 1'b1;
        shift <= head_rec.data;
        left  <= head_rec.nibbles;
      end
    end
  end

  // R3
  marker_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (pst == MRK_B || pst == MRK_W || pst == MRK_3B || pst == MRK_L));
  // R9
  comp_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_code != PST_IDLE) |-> !pop);
  // R3
  payload_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (head_rec.nibbles != 4'd0));
endmodule

// File: rtl/trace_status_enc.sv
module trace_status_enc
  import tse_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [2:0]        ev_class,
  input  logic              exc_active,
  input  logic              exc_is_reset,
  input  logic              capture_en,
  input  logic              tgt_en,
  input  logic              opnd_valid,
  input  logic [1:0]        opnd_size,
  input  logic [TRC_DW-1:0] opnd_data,
  input  logic              tgt_valid,
  input  logic [TRC_DW-1:0] tgt_addr,
  input  logic [TRC_DW-1:0] cur_pc,
  input  logic [2:0]        flow_mode,
  input  logic [3:0]        blk_addr_lo,
  input  logic [4:0]        blk_regs,
  output logic [3:0]        pst,
  output logic [3:0]        ddata,
  output logic              overflow
);
  logic [3:0] comp_code;
  logic [3:0] base_code;
  logic       rec_valid;
  trace_rec_t rec, head_rec;
  logic       fifo_empty, fifo_full, ser_pop, ser_busy;

  assign base_code = exc_active ? PST_EXC : PST_IDLE;

  tse_classify i_classify (
    .ev_valid, .ev_class, .exc_active, .exc_is_reset, .capture_en, .tgt_en,
    .opnd_valid, .opnd_size, .opnd_data, .tgt_valid, .tgt_addr, .cur_pc,
    .flow_mode, .blk_addr_lo, .blk_regs,
    .comp_code, .rec_valid, .rec
  );

  tse_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
    .clk, .rst_n,
    .push(rec_valid), .push_rec(rec), .pop(ser_pop), .head_rec,
    .empty(fifo_empty), .full(fifo_full), .overflow
  );

  tse_serializer i_ser (
    .clk, .rst_n, .comp_code, .base_code, .head_rec, .fifo_empty,
    .pop(ser_pop), .busy(ser_busy), .pst, .ddata
  );

  // R6
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_active && !(ev_valid && ev_class == 3'd2) && !ser_pop) |=> (pst == PST_EXC));
  // R8
  blk_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_class == 3'd3 && blk_addr_lo == 4'd0 && blk_regs >= 5'd4) |-> !rec_valid);
  // R11
  ignored_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid || ev_class >= 3'd6) |-> (!rec_valid && comp_code == PST_IDLE));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_busy |-> !ser_pop);
  // R2
  idle_pst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !exc_active && fifo_empty) |=> (pst == PST_IDLE));
endmodule

// File: tb/test_trace_status_enc.sv
module test_trace_status_enc;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 0, exc_active = 0, exc_is_reset = 0, capture_en = 0, tgt_en = 0;
  logic opnd_valid = 0, tgt_valid = 0;
  logic [2:0] ev_class = 0, flow_mode = 0;
  logic [1:0] opnd_size = 0;
  logic [31:0] opnd_data = 0, tgt_addr = 0, cur_pc = 0;
  logic [3:0] blk_addr_lo = 0;
  logic [4:0] blk_regs = 0;
  logic [3:0] pst, ddata;
  logic overflow;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  logic [3:0]  q_mrk [DEPTH];
  int          q_nib [DEPTH];
  logic [31:0] q_dat [DEPTH];
  int q_head = 0, q_cnt = 0;
  bit m_busy = 0, m_ovf = 0;
  int m_left = 0;
  logic [31:0] m_shift = 0;
  logic [3:0] m_pst = 0, m_dd = 0;

  always #(CLK_P/2) clk = ~clk;

  trace_status_enc i_trace_status_enc (
    .clk, .rst_n, .ev_valid, .ev_class, .exc_active, .exc_is_reset, .capture_en,
    .tgt_en, .opnd_valid, .opnd_size, .opnd_data, .tgt_valid, .tgt_addr, .cur_pc,
    .flow_mode, .blk_addr_lo, .blk_regs, .pst, .ddata, .overflow
  );

  function automatic int size_nibs(input logic [1:0] s);
    return (s == 0) ? 2 : (s == 1) ? 4 : 8;
  endfunction

  function automatic logic [3:0] size_mark(input logic [1:0] s);
    return (s == 0) ? 4'h8 : (s == 1) ? 4'h9 : 4'hB;
  endfunction

  function automatic logic [3:0] dist_mark(input logic [31:0] t, input logic [31:0] p);
    logic [31:0] d = t ^ p;
    if ((d >> 16) == 0) return 4'h9;
    if ((d >> 24) == 0) return 4'hA;
    return 4'hB;
  endfunction

  task automatic expect_event(output int comp, output bit rv, output logic [3:0] rm,
                              output int rn, output logic [31:0] rd);
    int code = 0;
    rv = 0; rm = size_mark(opnd_size); rn = size_nibs(opnd_size); rd = opnd_data;
    if (ev_valid) begin
      if (ev_class == 0) begin code = 1; rv = opnd_valid && capture_en; end
      if (ev_class == 1) begin code = 4; rv = opnd_valid; end
      if (ev_class == 2) begin
        code = 5;
        rv = tgt_valid && tgt_en && flow_mode != 0 && flow_mode < 6;
        rm = dist_mark(tgt_addr, cur_pc);
        rn = (rm == 4'h9) ? 4 : (rm == 4'hA) ? 6 : 8;
        rd = tgt_addr;
      end
      if (ev_class == 3) begin
        code = 1;
        rv = opnd_valid && capture_en && !(blk_addr_lo == 0 && blk_regs > 3);
      end
      if (ev_class == 4) rv = opnd_valid && capture_en;
      if (ev_class == 5) rv = opnd_valid && capture_en && !exc_is_reset;
    end
    comp = (exc_active && code != 5) ? 0 : code;
  endtask

  task automatic model_edge();
    int comp, rn; bit rv, popping; logic [3:0] rm; logic [31:0] rd;
    if (!rst_n) begin
      q_head = 0; q_cnt = 0; m_busy = 0; m_ovf = 0; m_left = 0;
      m_pst = 0; m_dd = 0; m_shift = 0;
      return;
    end
    expect_event(comp, rv, rm, rn, rd);
    popping = !m_busy && q_cnt > 0 && comp == 0;
    m_pst = (comp != 0) ? comp[3:0] : popping ? q_mrk[q_head] : (exc_active ? 4'hC : 4'h0);
    m_dd = m_busy ? m_shift[3:0] : 4'h0;
    if (m_busy) begin
      m_shift = m_shift >> 4; m_left--; if (m_left == 0) m_busy = 0;
    end
    if (rv) begin
      if (q_cnt == DEPTH) m_ovf = 1;
      else begin
        q_mrk[(q_head + q_cnt) % DEPTH] = rm;
        q_nib[(q_head + q_cnt) % DEPTH] = rn;
        q_dat[(q_head + q_cnt) % DEPTH] = rd;
      end
    end
    if (popping) begin
      m_busy = 1; m_shift = q_dat[q_head]; m_left = q_nib[q_head];
      q_head = (q_head + 1) % DEPTH; q_cnt--;
    end
    if (rv && !(q_cnt + (popping ? 1 : 0) == DEPTH)) q_cnt++;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(cur_req, "pst", {28'd0, pst}, {28'd0, m_pst});
    check(cur_req, "ddata", {28'd0, ddata}, {28'd0, m_dd});
    check(cur_req, "overflow", {31'd0, overflow}, {31'd0, m_ovf});
  endtask

  task automatic idle(input int n);
    ev_valid = 0; opnd_valid = 0; tgt_valid = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic ev(input logic [2:0] c, input bit ov, input logic [1:0] sz,
                    input logic [31:0] d);
    ev_valid = 1; ev_class = c; opnd_valid = ov; opnd_size = sz; opnd_data = d;
    tgt_valid = 0;
    step();
    ev_valid = 0; opnd_valid = 0;
  endtask

  task automatic flow(input logic [2:0] mode, input logic [31:0] pc, input logic [31:0] t);
    ev_valid = 1; ev_class = 2; flow_mode = mode; cur_pc = pc; tgt_addr = t;
    tgt_valid = 1; opnd_valid = 0;
    step();
    ev_valid = 0; tgt_valid = 0;
  endtask

  task automatic collect(input int n, output logic [31:0] w);
    w = 0;
    for (int i = 0; i < n; i++) begin
      step();
      w = w | ({28'd0, ddata} << (4 * i));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(1234));
    cur_req = "R1";
    for (int i = 0; i < 3; i++) step();
    rst_n = 1;
    step();
    check("R1", "pst after reset", {28'd0, pst}, 32'h0);
    check("R1", "ddata after reset", {28'd0, ddata}, 32'h0);
    check("R1", "overflow after reset", {31'd0, overflow}, 32'h0);

    cur_req = "R2";
    ev(0, 0, 0, 0);
    check("R2", "plain code", {28'd0, pst}, 32'h1);
    idle(2);
    check("R2", "idle code", {28'd0, pst}, 32'h0);

    cur_req = "R3"; capture_en = 1;
    ev(0, 1, 2, 32'h89AB_CDEF);
    step();
    check("R3", "long marker", {28'd0, pst}, 32'hB);
    collect(8, w);
    check("R3", "long payload", w, 32'h89AB_CDEF);
    ev(0, 1, 0, 32'h0000_005A); idle(4);
    ev(3, 1, 1, 32'h0000_1234); idle(6);
    capture_en = 0;
    ev(0, 1, 2, 32'hDEAD_BEEF); idle(4);

    cur_req = "R4";
    ev(1, 1, 1, 32'h0000_C0DE);
    check("R4", "wddata code", {28'd0, pst}, 32'h4);
    step();
    check("R4", "wddata marker", {28'd0, pst}, 32'h9);
    idle(5);

    cur_req = "R5"; tgt_en = 1;
    flow(3, 32'h1234_0000, 32'h1256_7890);
    check("R5", "flow code", {28'd0, pst}, 32'h5);
    step();
    check("R5", "24-bit marker", {28'd0, pst}, 32'hA);
    collect(6, w);
    check("R5", "24-bit payload", w, 32'h0056_7890);
    flow(1, 32'h1234_0000, 32'h1234_9876); idle(6);
    flow(4, 32'h1234_0000, 32'hFF00_0010); idle(10);
    flow(0, 32'h1234_0000, 32'hFF00_0010); idle(2);
    flow(6, 32'h1234_0000, 32'hFF00_0010); idle(2);
    tgt_en = 0; flow(2, 32'h0, 32'h4000_0000); idle(2); tgt_en = 1;

    cur_req = "R6"; capture_en = 1; exc_active = 1;
    step();
    check("R6", "exception hold", {28'd0, pst}, 32'hC);
    ev(0, 0, 0, 0);
    check("R6", "masked plain", {28'd0, pst}, 32'hC);
    cur_req = "R7";
    ev(4, 1, 2, 32'h1111_2222); ev(4, 1, 2, 32'h3333_4444);
    ev(5, 1, 2, 32'h0000_0100); flow(5, 32'h0, 32'h0000_0400);
    idle(40);
    exc_is_reset = 1;
    ev(5, 1, 2, 32'h0); ev(5, 1, 2, 32'h4); flow(5, 32'h0, 32'h0000_0800);
    idle(10);
    exc_active = 0; exc_is_reset = 0; idle(2);

    cur_req = "R8";
    blk_addr_lo = 0; blk_regs = 4; ev(3, 1, 2, 32'hAAAA_AAAA); idle(2);
    check("R8", "burst suppressed", {28'd0, pst}, 32'h0);
    blk_regs = 3; ev(3, 1, 2, 32'hBBBB_BBBB); idle(10);
    blk_addr_lo = 4; blk_regs = 8; ev(3, 1, 2, 32'hCCCC_CCCC); idle(10);

    cur_req = "R9";
    ev(0, 1, 1, 32'h0000_1357); ev(0, 1, 0, 32'h0000_0024);
    ev(1, 0, 0, 0); ev(0, 0, 0, 0);
    check("R9", "marker deferred", {28'd0, pst}, 32'h1);
    idle(16);

    cur_req = "R11";
    ev_valid = 0; opnd_valid = 1; ev_class = 0; step(); opnd_valid = 0;
    ev(6, 1, 2, 32'h5555_5555); ev(7, 1, 2, 32'h6666_6666);
    idle(2);
    check("R11", "ignored classes", {28'd0, pst}, 32'h0);

    cur_req = "R10";
    for (int i = 0; i < 12; i++) begin
      ev(4, 1, 2, 32'h1000_0000 + i);
    end
    check("R10", "overflow set", {31'd0, overflow}, 32'h1);
    idle(120);
    check("R10", "overflow sticky", {31'd0, overflow}, 32'h1);

    rst_n = 0; step(); step(); rst_n = 1; step();
    cur_req = "R9";
    for (int i = 0; i < 2500; i++) begin
      int lvl;
      ev_valid   = ($urandom % 10) < 6;
      ev_class   = 3'($urandom % 8);
      opnd_valid = $urandom % 2;
      opnd_size  = 2'($urandom % 4);
      opnd_data  = $urandom;
      capture_en = ($urandom % 4) != 0;
      tgt_en     = ($urandom % 4) != 0;
      tgt_valid  = $urandom % 2;
      flow_mode  = 3'($urandom % 8);
      cur_pc     = $urandom;
      lvl        = $urandom % 3;
      tgt_addr   = cur_pc ^ ((lvl == 0) ? ($urandom & 32'h0000_FFFF) :
                             (lvl == 1) ? (($urandom & 32'h00FF_FFFF) | 32'h0001_0000) :
                                          ($urandom | 32'h0100_0000));
      blk_addr_lo = ($urandom % 2) ? 4'd0 : 4'($urandom);
      blk_regs    = 5'($urandom % 9);
      if (($urandom % 16) == 0) exc_active = !exc_active;
      if (($urandom % 16) == 0) exc_is_reset = !exc_is_reset;
      step();
    end
    idle(20);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule